// File: doc/BRIEF.md
# Sub-entry sharing translation buffer

This block is a small fully associative translation lookaside buffer. Each entry covers one 1MB-aligned virtual region. The region is split into 16 slots, and each slot holds the physical page number of one 64KB page. The virtual page number (VPN) counts 64KB pages. Its low four bits pick the page within a region, and the bits above them form the region tag.

Regions are often only lightly used, so a non-shared entry with at most half of its slots valid can be converted into a split entry that serves two regions:

- The original owner keeps its translations, compacted into the lower half of the slots.
- The newcomer takes the upper half.

Inside a split entry each slot records its own page index, so a page can sit in any slot of its owner's half.

Lookups are answered one cycle after they are accepted. Fills carry translations returned from a page walk and take priority over lookups. A flush input empties the whole buffer and returns every entry to non-shared mode.

Top module: `subshare_tlb`

## Requirements
- R1: After reset every lookup misses, `rsp_valid` is low and `lookup_ready` is high while neither `fill_valid` nor `flush` is asserted.
- R2: A lookup accepted in cycle n (`req_valid` and `lookup_ready` high) produces `rsp_valid` high in cycle n+1. `rsp_valid` is low in any cycle that follows a cycle without an accepted lookup, and `rsp_hit` is only high together with `rsp_valid`.
- R3: While `fill_valid` or `flush` is high, `lookup_ready` is low and a request presented in that cycle produces no response.
- R4: The region tag is VPN bits [VPN_W-1:4] and the page index is VPN bits [3:0]. In a non-shared entry the page index selects the slot directly. A filled page hits with its physical page and `rsp_shared`=0, while an unfilled page of the same region misses.
- R5: A fill whose region matches no entry is installed, in non-shared mode, in the lowest-numbered entry that holds no region, if such an entry exists. Earlier regions are left intact.
- R6: When no empty entry exists, a fill for a new region converts the lowest-numbered non-shared entry with at most 8 valid slots into a split entry. The old owner's translations are kept and still hit, the new region's page hits, and both report `rsp_shared`=1.
- R7: Each owner of a split entry holds at most 8 pages. A fill for a new page into a full half replaces the slot at that half's rotating pointer. The pointer starts at the half's lowest slot and advances by one per replacement. The other half is unaffected.
- R8: A fill for a page that is already present overwrites its physical page in place, in both modes.
- R9: When no empty or sparse entry exists, a fill for a new region evicts the least recently used entry and installs the new region in non-shared mode. An entry counts as used when a lookup hits it or a fill writes it.
- R10: A flush clears all translations within one cycle and returns every entry to non-shared mode, so later fills install as non-shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate every translation |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| lookup_ready | output | 1 | Lookup accepted this cycle |
| rsp_valid | output | 1 | Registered lookup result present |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | PPN_W | Physical page number on a hit, zero otherwise |
| rsp_shared | output | 1 | Hitting entry is in split mode |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Virtual page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |

## Verification
Some properties are checked by assertions on every cycle:

- the lookup stall while a fill or flush is present;
- the one-cycle response timing;
- the rule that a split-mode report implies a hit;
- that no split entry exists without an owner;
- that a flush leaves every entry empty and non-shared in the following cycle.

Other properties can only be shown through the bench's scenarios, because they depend on the history of fills and lookups:

- where a new region lands;
- whether a sparse entry is converted with its old pages intact;
- which slot a full half gives up;
- which entry least-recently-used eviction picks.

// File: rtl/subshare_tlb_pkg.sv
package subshare_tlb_pkg;
   localparam int SUB_N  = 16;
   localparam int HALF_N = SUB_N / 2;
   localparam int IDX_W  = $clog2(SUB_N);
   localparam int PTR_W  = $clog2(HALF_N);

   typedef logic [SUB_N-1:0]            slot_mask_t;
   typedef logic [SUB_N-1:0][IDX_W-1:0] pidx_vec_t;

   typedef struct packed {
      logic             split;
      logic             own_a;
      logic             own_b;
      logic [PTR_W-1:0] ptr_a;
      logic [PTR_W-1:0] ptr_b;
      slot_mask_t       sv;
   } ent_meta_t;

   function automatic slot_mask_t own_mask(logic split, logic a, logic b);
      own_mask = split ? {{HALF_N{b}}, {HALF_N{a}}} : {SUB_N{a}};
   endfunction
endpackage

// File: rtl/subshare_tlb_match.sv
module subshare_tlb_match
   import subshare_tlb_pkg::*;
#(
   parameter int TAG_W = 12
) (
   input  logic             split,
   input  logic             own_a_v,
   input  logic             own_b_v,
   input  slot_mask_t       sv,
   input  pidx_vec_t        pidx,
   input  logic [TAG_W-1:0] tag_a,
   input  logic [TAG_W-1:0] tag_b,
   input  logic [TAG_W-1:0] key_tag,
   input  logic [IDX_W-1:0] key_pi,
   output logic             own_a_hit,
   output logic             own_b_hit,
   output slot_mask_t       pidx_hit
);
   assign own_a_hit = own_a_v && (tag_a == key_tag);
   assign own_b_hit = split && own_b_v && (tag_b == key_tag);

   for (genvar s = 0; s < SUB_N; s++) begin : g_slot
      assign pidx_hit[s] = sv[s] && (pidx[s] == key_pi);
   end
endmodule

// File: rtl/subshare_tlb_lru.sv
module subshare_tlb_lru #(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 touch_v,
   input  logic [$clog2(N)-1:0] touch_idx,
   output logic [$clog2(N)-1:0] victim
);
   localparam int EW = $clog2(N);
   logic [EW-1:0] age_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age_q[i] <= EW'(i);
      end else if (touch_v) begin
         for (int i = 0; i < N; i++) begin
            if (EW'(i) == touch_idx)              age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      victim = '0;
      for (int i = 0; i < N; i++)
         if (age_q[i] == EW'(N-1)) victim = EW'(i);
   end
endmodule

// File: rtl/subshare_tlb.sv
module subshare_tlb
   import subshare_tlb_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 16,
   parameter int PPN_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             req_valid,
   input  logic [VPN_W-1:0] req_vpn,
   output logic             lookup_ready,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic [PPN_W-1:0] rsp_ppn,
   output logic             rsp_shared,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn
);
   localparam int TAG_W = VPN_W - IDX_W;
   localparam int EW    = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("subshare_tlb: ENTRIES must be at least 2");
   end
   if (VPN_W <= IDX_W) begin : g_bad_vpn
      $error("subshare_tlb: VPN_W must exceed the page index width");
   end
   if (PPN_W < 1) begin : g_bad_ppn
      $error("subshare_tlb: PPN_W must be positive");
   end

   ent_meta_t        meta_q [ENTRIES], meta_d [ENTRIES];
   pidx_vec_t        pidx_q [ENTRIES], pidx_d [ENTRIES];
   logic [TAG_W-1:0] taga_q [ENTRIES], taga_d [ENTRIES];
   logic [TAG_W-1:0] tagb_q [ENTRIES], tagb_d [ENTRIES];
   logic [PPN_W-1:0] ppn_q  [ENTRIES][SUB_N], ppn_d [ENTRIES][SUB_N];

   logic [TAG_W-1:0] rq_tag, fl_tag;
   logic [IDX_W-1:0] rq_pi, fl_pi;
   assign rq_tag = req_vpn[VPN_W-1:IDX_W];
   assign rq_pi  = req_vpn[IDX_W-1:0];
   assign fl_tag = fill_vpn[VPN_W-1:IDX_W];
   assign fl_pi  = fill_vpn[IDX_W-1:0];

   logic [ENTRIES-1:0] l_a, l_b, f_a, f_b, mode_vec, live_vec;
   slot_mask_t         l_pix [ENTRIES], f_pix [ENTRIES];
   slot_mask_t         l_slot[ENTRIES], f_slot[ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign mode_vec[e] = meta_q[e].split;
      assign live_vec[e] = meta_q[e].own_a;
      subshare_tlb_match #(.TAG_W(TAG_W)) u_lk (
         .split(meta_q[e].split), .own_a_v(meta_q[e].own_a), .own_b_v(meta_q[e].own_b),
         .sv(meta_q[e].sv), .pidx(pidx_q[e]), .tag_a(taga_q[e]), .tag_b(tagb_q[e]),
         .key_tag(rq_tag), .key_pi(rq_pi),
         .own_a_hit(l_a[e]), .own_b_hit(l_b[e]), .pidx_hit(l_pix[e]));
      subshare_tlb_match #(.TAG_W(TAG_W)) u_fl (
         .split(meta_q[e].split), .own_a_v(meta_q[e].own_a), .own_b_v(meta_q[e].own_b),
         .sv(meta_q[e].sv), .pidx(pidx_q[e]), .tag_a(taga_q[e]), .tag_b(tagb_q[e]),
         .key_tag(fl_tag), .key_pi(fl_pi),
         .own_a_hit(f_a[e]), .own_b_hit(f_b[e]), .pidx_hit(f_pix[e]));
      assign l_slot[e] = l_pix[e] & own_mask(meta_q[e].split, l_a[e], l_b[e]);
      assign f_slot[e] = f_pix[e] & own_mask(meta_q[e].split, f_a[e], f_b[e]);
   end

   // lookup side
   logic             acc, l_any, l_sh;
   logic [EW-1:0]    l_idx;
   logic [PPN_W-1:0] l_ppn;
   assign lookup_ready = !(fill_valid || flush);
   assign acc          = req_valid && lookup_ready;

   always_comb begin
      l_any = 1'b0; l_sh = 1'b0; l_idx = '0; l_ppn = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (|l_slot[e]) begin
            l_any = 1'b1;
            l_idx = EW'(e);
            l_sh  = mode_vec[e];
            for (int s = 0; s < SUB_N; s++)
               if (l_slot[e][s]) l_ppn = ppn_q[e][s];
         end
      end
   end

   // fill side
   logic             hit_found, hb, free_found, sp_found, slot_found;
   logic [EW-1:0]    he, free_idx, sp_idx, vic, lru_vic, touch_idx;
   logic [IDX_W-1:0] base, tslot, k;
   logic [PTR_W-1:0] ptr;
   logic             touch_v;

   always_comb begin
      meta_d = meta_q; pidx_d = pidx_q; taga_d = taga_q; tagb_d = tagb_q; ppn_d = ppn_q;
      hit_found = 1'b0; hb = 1'b0; he = '0;
      free_found = 1'b0; free_idx = '0; sp_found = 1'b0; sp_idx = '0; vic = '0;
      slot_found = 1'b0; base = '0; tslot = '0; k = '0; ptr = '0;
      touch_v = acc && l_any; touch_idx = l_idx;
      for (int e = ENTRIES-1; e >= 0; e--) begin
         if (f_a[e] || f_b[e]) begin hit_found = 1'b1; he = EW'(e); hb = f_b[e]; end
         if (!live_vec[e]) begin free_found = 1'b1; free_idx = EW'(e); end
         if (live_vec[e] && !mode_vec[e] && ($countones(meta_q[e].sv) <= HALF_N)) begin
            sp_found = 1'b1; sp_idx = EW'(e);
         end
      end
      if (flush) begin
         for (int e = 0; e < ENTRIES; e++) meta_d[e] = '0;
         touch_v = 1'b0;
      end else if (fill_valid && hit_found) begin
         touch_v = 1'b1; touch_idx = he;
         if (!meta_q[he].split) begin
            tslot = fl_pi;
         end else begin
            base = hb ? IDX_W'(HALF_N) : '0;
            ptr  = hb ? meta_q[he].ptr_b : meta_q[he].ptr_a;
            for (int s = HALF_N-1; s >= 0; s--)
               if (!meta_q[he].sv[base + IDX_W'(s)]) tslot = base + IDX_W'(s);
            for (int s = HALF_N-1; s >= 0; s--)
               if (f_slot[he][base + IDX_W'(s)]) begin
                  slot_found = 1'b1; tslot = base + IDX_W'(s);
               end
            if (!slot_found && (&meta_q[he].sv[base +: HALF_N])) begin
               tslot = base + {1'b0, ptr};
               if (hb) meta_d[he].ptr_b = ptr + 1'b1;
               else    meta_d[he].ptr_a = ptr + 1'b1;
            end
         end
         meta_d[he].sv[tslot] = 1'b1;
         pidx_d[he][tslot]    = fl_pi;
         ppn_d[he][tslot]     = fill_ppn;
      end else if (fill_valid && (free_found || !sp_found)) begin
         vic = free_found ? free_idx : lru_vic;
         touch_v = 1'b1; touch_idx = vic;
         meta_d[vic]           = '0;
         meta_d[vic].own_a     = 1'b1;
         meta_d[vic].sv[fl_pi] = 1'b1;
         taga_d[vic]           = fl_tag;
         for (int s = 0; s < SUB_N; s++) pidx_d[vic][s] = IDX_W'(s);
         ppn_d[vic][fl_pi]     = fill_ppn;
      end else if (fill_valid) begin
         touch_v = 1'b1; touch_idx = sp_idx;
         meta_d[sp_idx].sv = '0;
         for (int s = 0; s < SUB_N; s++) begin
            if (meta_q[sp_idx].sv[s]) begin
               meta_d[sp_idx].sv[k] = 1'b1;
               pidx_d[sp_idx][k]    = pidx_q[sp_idx][s];
               ppn_d[sp_idx][k]     = ppn_q[sp_idx][s];
               k = k + 1'b1;
            end
         end
         meta_d[sp_idx].split          = 1'b1;
         meta_d[sp_idx].own_b          = 1'b1;
         meta_d[sp_idx].ptr_a          = '0;
         meta_d[sp_idx].ptr_b          = '0;
         meta_d[sp_idx].sv[HALF_N]     = 1'b1;
         tagb_d[sp_idx]                = fl_tag;
         pidx_d[sp_idx][HALF_N]        = fl_pi;
         ppn_d[sp_idx][HALF_N]         = fill_ppn;
      end
   end

   subshare_tlb_lru #(.N(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch_v(touch_v), .touch_idx(touch_idx), .victim(lru_vic));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            meta_q[e] <= '0; pidx_q[e] <= '0; taga_q[e] <= '0; tagb_q[e] <= '0;
            for (int s = 0; s < SUB_N; s++) ppn_q[e][s] <= '0;
         end
         rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_ppn <= '0; rsp_shared <= 1'b0;
      end else begin
         meta_q <= meta_d; pidx_q <= pidx_d; taga_q <= taga_d; tagb_q <= tagb_d; ppn_q <= ppn_d;
         rsp_valid  <= acc;
         rsp_hit    <= acc && l_any;
         rsp_ppn    <= (acc && l_any) ? l_ppn : '0;
         rsp_shared <= acc && l_any && l_sh;
      end
   end
endmodule

// File: rtl/subshare_tlb_chk.sv
module subshare_tlb_chk #(
   parameter int ENTRIES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flush,
   input logic               fill_valid,
   input logic               req_valid,
   input logic               lookup_ready,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               rsp_shared,
   input logic [ENTRIES-1:0] mode_vec,
   input logic [ENTRIES-1:0] live_vec
);
   p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid || flush) |-> !lookup_ready);

   p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && lookup_ready) |=> rsp_valid);

   p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && lookup_ready) |=> !rsp_valid);

   p_hit_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);

   p_split_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_shared |-> rsp_hit);

   p_split_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec & ~live_vec) == '0);

   p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (mode_vec == '0) && (live_vec == '0));
endmodule

bind subshare_tlb subshare_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
   .req_valid(req_valid), .lookup_ready(lookup_ready), .rsp_valid(rsp_valid),
   .rsp_hit(rsp_hit), .rsp_shared(rsp_shared), .mode_vec(mode_vec), .live_vec(live_vec));

// File: tb/subshare_tlb_tb.sv
`timescale 1ns/1ps
module subshare_tlb_tb;
   localparam int VPN_W = 16;
   localparam int PPN_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             flush = 1'b0, req_valid = 1'b0, fill_valid = 1'b0;
   logic [VPN_W-1:0] req_vpn = '0, fill_vpn = '0;
   logic [PPN_W-1:0] fill_ppn = '0;
   logic             lookup_ready, rsp_valid, rsp_hit, rsp_shared;
   logic [PPN_W-1:0] rsp_ppn;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   subshare_tlb #(.ENTRIES(4), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_vpn(req_vpn),
      .lookup_ready(lookup_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_ppn(rsp_ppn), .rsp_shared(rsp_shared), .fill_valid(fill_valid),
      .fill_vpn(fill_vpn), .fill_ppn(fill_ppn));

   typedef struct packed {
      logic             look;
      logic [VPN_W-1:0] vpn;
      logic [PPN_W-1:0] ppn;
      logic             hit;
      logic             sh;
      logic [7:0]       req;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 16'h0013, 12'h101, 1'b0, 1'b0, 8'd4},
      '{1'b1, 16'h0013, 12'h101, 1'b1, 1'b0, 8'd4},  // R4 filled page hits
      '{1'b1, 16'h0014, 12'h000, 1'b0, 1'b0, 8'd4},  // R4 neighbour page misses
      '{1'b0, 16'h0014, 12'h102, 1'b0, 1'b0, 8'd4},
      '{1'b1, 16'h0014, 12'h102, 1'b1, 1'b0, 8'd4},
      '{1'b0, 16'h0020, 12'h200, 1'b0, 1'b0, 8'd5},
      '{1'b0, 16'h0030, 12'h300, 1'b0, 1'b0, 8'd5},
      '{1'b0, 16'h0040, 12'h400, 1'b0, 1'b0, 8'd5},
      '{1'b1, 16'h0020, 12'h200, 1'b1, 1'b0, 8'd5},  // R5 free entries used
      '{1'b1, 16'h0030, 12'h300, 1'b1, 1'b0, 8'd5},
      '{1'b1, 16'h0040, 12'h400, 1'b1, 1'b0, 8'd5},
      '{1'b1, 16'h0013, 12'h101, 1'b1, 1'b0, 8'd5},
      '{1'b0, 16'h0057, 12'h577, 1'b0, 1'b0, 8'd6},
      '{1'b1, 16'h0057, 12'h577, 1'b1, 1'b1, 8'd6},  // R6 newcomer in split entry
      '{1'b1, 16'h0013, 12'h101, 1'b1, 1'b1, 8'd6},  // R6 old owner compacted
      '{1'b1, 16'h0014, 12'h102, 1'b1, 1'b1, 8'd6},
      '{1'b1, 16'h0020, 12'h200, 1'b1, 1'b0, 8'd6},
      '{1'b0, 16'h0013, 12'h1AA, 1'b0, 1'b0, 8'd8},
      '{1'b1, 16'h0013, 12'h1AA, 1'b1, 1'b1, 8'd8},  // R8 in place, split mode
      '{1'b0, 16'h0050, 12'h500, 1'b0, 1'b0, 8'd7},
      '{1'b0, 16'h0051, 12'h501, 1'b0, 1'b0, 8'd7},
      '{1'b0, 16'h0052, 12'h502, 1'b0, 1'b0, 8'd7},
      '{1'b0, 16'h0053, 12'h503, 1'b0, 1'b0, 8'd7},
      '{1'b0, 16'h0054, 12'h504, 1'b0, 1'b0, 8'd7},
      '{1'b0, 16'h0055, 12'h505, 1'b0, 1'b0, 8'd7},
      '{1'b0, 16'h0056, 12'h506, 1'b0, 1'b0, 8'd7},
      '{1'b1, 16'h0056, 12'h506, 1'b1, 1'b1, 8'd7},
      '{1'b1, 16'h0057, 12'h577, 1'b1, 1'b1, 8'd7},  // R7 half now full
      '{1'b0, 16'h0058, 12'h508, 1'b0, 1'b0, 8'd7},
      '{1'b1, 16'h0057, 12'h000, 1'b0, 1'b0, 8'd7},  // R7 slot at pointer replaced
      '{1'b1, 16'h0050, 12'h500, 1'b1, 1'b1, 8'd7},
      '{1'b1, 16'h0058, 12'h508, 1'b1, 1'b1, 8'd7},
      '{1'b1, 16'h0014, 12'h102, 1'b1, 1'b1, 8'd7},  // R7 other half intact
      '{1'b0, 16'h0020, 12'h2BB, 1'b0, 1'b0, 8'd8},
      '{1'b1, 16'h0020, 12'h2BB, 1'b1, 1'b0, 8'd8},  // R8 in place, non-shared
      '{1'b1, 16'h0021, 12'h000, 1'b0, 1'b0, 8'd8}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = v; fill_ppn = p;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic do_look(input string req, input logic [VPN_W-1:0] v,
                          input logic hit, input logic [PPN_W-1:0] p, input logic sh);
      @(negedge clk);
      req_valid = 1'b1; req_vpn = v;
      @(negedge clk);
      req_valid = 1'b0;
      chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({req, " hit"}, 32'(rsp_hit), 32'(hit));
      if (hit) chk({req, " ppn"}, 32'(rsp_ppn), 32'(p));
      chk({req, " shared"}, 32'(rsp_shared), 32'(sh));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R1 lookup_ready", 32'(lookup_ready), 32'd1);
      do_look("R1", 16'h0013, 1'b0, 12'h0, 1'b0);
      @(negedge clk);
      chk("R2 idle rsp_valid", 32'(rsp_valid), 32'd0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].look)
            do_look($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].vpn, VEC[i].hit,
                    VEC[i].ppn, VEC[i].sh);
         else
            do_fill(VEC[i].vpn, VEC[i].ppn);
      end

      // R3 fill blocks a same-cycle lookup
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = 16'h0099; fill_ppn = 12'h999;
      req_valid = 1'b1; req_vpn = 16'h0013;
      #1 chk("R3 ready during fill", 32'(lookup_ready), 32'd0);
      @(negedge clk);
      fill_valid = 1'b0; req_valid = 1'b0;
      chk("R3 no response", 32'(rsp_valid), 32'd0);
      // R3 flush blocks a same-cycle lookup; R10 flush clears all
      @(negedge clk);
      flush = 1'b1; req_valid = 1'b1; req_vpn = 16'h0013;
      #1 chk("R3 ready during flush", 32'(lookup_ready), 32'd0);
      @(negedge clk);
      flush = 1'b0; req_valid = 1'b0;
      chk("R3 no response flush", 32'(rsp_valid), 32'd0);
      do_look("R10 split gone", 16'h0013, 1'b0, 12'h0, 1'b0);
      do_look("R10 b gone", 16'h0058, 1'b0, 12'h0, 1'b0);
      do_look("R10 plain gone", 16'h0040, 1'b0, 12'h0, 1'b0);
      do_fill(16'h0013, 12'h333);
      do_look("R10 refill non-shared", 16'h0013, 1'b1, 12'h333, 1'b0);

      // R9 least recently used eviction among dense entries
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      for (int t = 10; t < 14; t++)
         for (int p = 0; p < 9; p++)
            do_fill(VPN_W'(t * 16 + p), PPN_W'(t * 16 + p));
      do_look("R9 touch A", 16'h00A0, 1'b1, 12'h0A0, 1'b0);
      do_fill(16'h00E0, 12'h0E0);
      do_look("R9 lru B evicted", 16'h00B0, 1'b0, 12'h0, 1'b0);
      do_look("R9 A kept", 16'h00A0, 1'b1, 12'h0A0, 1'b0);
      do_look("R9 new region", 16'h00E0, 1'b1, 12'h0E0, 1'b0);
      do_look("R9 C kept", 16'h00C8, 1'b1, 12'h0C8, 1'b0);
      do_look("R9 D kept", 16'h00D3, 1'b1, 12'h0D3, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule